// File: doc/BRIEF.md
# NaN Classify and Quieting Unit

This block takes one single-precision floating-point operand per cycle, sorts it into one of six classes and, when the operand is a signaling NaN, produces the matching quiet NaN and raises an invalid-operation flag. It sits in front of arithmetic datapaths that need to know an operand's class and must never propagate a signaling NaN.

A mode input selects how NaNs are encoded. With the 2008 convention (`nan2008` = 1), fraction bit 22 set marks a quiet NaN. With the legacy convention (`nan2008` = 0), bit 22 set marks a signaling NaN. Quieting under the legacy convention clears bit 22. If that would leave an all-zero fraction, which encodes infinity, the unit sets fraction bit 21 instead.

Results are registered. A two-state output controller holds the result. In state EMPTY no result is valid. The transition FILL (EMPTY to LOADED, on `in_valid`) presents a new result. The transition REFILL (LOADED to LOADED, on `in_valid`) replaces it. The transition DRAIN (LOADED to EMPTY, when `in_valid` is low) drops `out_valid`. The transition IDLE (EMPTY to EMPTY) keeps it low. The data registers change only when `in_valid` is high.

Top module: `fp_nan_quieter`

## Requirements
- R1: Class codes on `out_class`: 0 when the exponent field [30:23] is zero and the fraction [22:0] is zero; 1 when the exponent is zero and the fraction is nonzero; 2 when the exponent is 1 to 254; 3 when the exponent is 255 and the fraction is zero.
- R2: With exponent 255 and a nonzero fraction, the class is 4 (quiet) or 5 (signaling). Under `nan2008`=1 the class is 5 exactly when bit 22 is 0. Under `nan2008`=0 the class is 5 exactly when bit 22 is 1.
- R3: Under `nan2008`=1, a signaling NaN leaves with bit 22 set and `out_invalid`=1.
- R4: Under `nan2008`=0, a signaling NaN leaves with bit 22 cleared and `out_invalid`=1. If bits [21:0] are all zero, bit 21 is set so that the result stays a NaN.
- R5: Quieting never alters the sign bit 31, the exponent, or any fraction bit other than bits 22 and 21 as stated in R3 and R4.
- R6: An operand that is not a signaling NaN appears on `out_value` unchanged, with `out_invalid`=0.
- R7: A result appears one clock after the operand is accepted with `in_valid`=1. `out_valid` is high in exactly that cycle after each accepting cycle. While `in_valid` is low, `out_value`, `out_class` and `out_invalid` hold.
- R8: During and after reset, before any operand is accepted, `out_valid`, `out_class`, `out_value` and `out_invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | Single-precision operand |
| nan2008 | input | 1 | 1: 2008 NaN convention, 0: legacy convention |
| out_valid | output | 1 | Result registers hold a result accepted last cycle |
| out_class | output | 3 | Class code of the result's operand |
| out_value | output | 32 | Operand, quieted if it was signaling |
| out_invalid | output | 1 | Invalid-operation flag, set when a signaling NaN was quieted |

## Verification
The bench targets the legacy NaN with only bit 22 set (0x7FC00000 and its negative). A design that skips the fix-up would return 0x7F800000, which is infinity. The bench also sends legacy NaNs with bit 21 already set, where the fix-up must not fire. A design that tests the wrong bit or inverts the mode would swap classes 4 and 5 and flag quiet NaNs as invalid. The bench compares results at both exponent edges (exponent 0 with fraction 1, exponent 1, exponent 254, exponent 255 with fraction 0) and after gaps in `in_valid`. A design with a wrong threshold or a missing hold would give the wrong class or a stale `out_valid`.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_QNAN = 3'd4,
        CLS_SNAN = 3'd5
    } fp_class_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } hold_state_e;

endpackage

// File: rtl/fpq_classify.sv
module fpq_classify
    import fpq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    input  logic                  nan2008,
    output fp_class_e             cls,
    output logic                  is_snan
);
    localparam int QBIT = FRAC_W - 1;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_zero;
    logic              qbit_set;

    assign expo      = op[EXP_W+FRAC_W-1:FRAC_W];
    assign frac      = op[FRAC_W-1:0];
    assign exp_zero  = (expo == '0);
    assign exp_ones  = (expo == '1);
    assign frac_zero = (frac == '0);
    assign qbit_set  = frac[QBIT];

    always_comb begin
        is_snan = 1'b0;
        unique case ({exp_zero, exp_ones})
            2'b10:   cls = frac_zero ? CLS_ZERO : CLS_SUB;
            2'b01: begin
                if (frac_zero) begin
                    cls = CLS_INF;
                end else begin
                    is_snan = nan2008 ? !qbit_set : qbit_set;
                    cls     = is_snan ? CLS_SNAN : CLS_QNAN;
                end
            end
            default: cls = CLS_NORM;
        endcase
    end
endmodule

// File: rtl/fpq_quiet.sv
module fpq_quiet #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    input  logic                  is_snan,
    input  logic                  nan2008,
    output logic [EXP_W+FRAC_W:0] value
);
    localparam int QBIT   = FRAC_W - 1;
    localparam int BACKUP = FRAC_W - 2;

    logic [FRAC_W-1:0] frac_in;
    logic [FRAC_W-1:0] frac_cleared;
    logic [FRAC_W-1:0] frac_out;

    assign frac_in      = op[FRAC_W-1:0];
    assign frac_cleared = frac_in & ~(FRAC_W'(1) << QBIT);

    always_comb begin
        frac_out = frac_in;
        if (is_snan) begin
            if (nan2008) begin
                frac_out = frac_in | (FRAC_W'(1) << QBIT);
            end else if (frac_cleared == '0) begin
                frac_out = FRAC_W'(1) << BACKUP;
            end else begin
                frac_out = frac_cleared;
            end
        end
    end

    assign value = {op[EXP_W+FRAC_W:FRAC_W], frac_out};
endmodule

// File: rtl/fp_nan_quieter.sv
module fp_nan_quieter
    import fpq_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_op,
    input  logic              nan2008,
    output logic              out_valid,
    output logic [2:0]        out_class,
    output logic [WORD_W-1:0] out_value,
    output logic              out_invalid
);
    fp_class_e         cls_c;
    logic              snan_c;
    logic [WORD_W-1:0] value_c;

    hold_state_e       state_q;
    hold_state_e       state_d;
    fp_class_e         class_q;
    logic [WORD_W-1:0] value_q;
    logic              invalid_q;

    fpq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .op      (in_op),
        .nan2008 (nan2008),
        .cls     (cls_c),
        .is_snan (snan_c)
    );

    fpq_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
        .op      (in_op),
        .is_snan (snan_c),
        .nan2008 (nan2008),
        .value   (value_c)
    );

    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = in_valid ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = in_valid ? ST_LOADED : ST_EMPTY;
            default:   state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            class_q   <= CLS_ZERO;
            value_q   <= '0;
            invalid_q <= 1'b0;
        end else if (in_valid) begin
            class_q   <= cls_c;
            value_q   <= value_c;
            invalid_q <= snan_c;
        end
    end

    assign out_valid   = (state_q == ST_LOADED);
    assign out_class   = class_q;
    assign out_value   = value_q;
    assign out_invalid = invalid_q;
endmodule

// File: rtl/fp_nan_quieter_chk.sv
module fp_nan_quieter_chk #(
    parameter int WORD_W = 32,
    parameter int FRAC_W = 23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_op,
    input logic              out_valid,
    input logic [2:0]        out_class,
    input logic [WORD_W-1:0] out_value,
    input logic              out_invalid
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R7
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R7
    AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_value) && $stable(out_class) && $stable(out_invalid)); // R7
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_value[WORD_W-1] == $past(in_op[WORD_W-1])); // R5
    AST_FLAG_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_class == 3'd5); // R6
    AST_QUIET_STAYS_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_value[WORD_W-2:FRAC_W] == '1) && (out_value[FRAC_W-1:0] != '0)); // R4
    AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_class <= 3'd5); // R1
endmodule

bind fp_nan_quieter fp_nan_quieter_chk #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .out_valid   (out_valid),
    .out_class   (out_class),
    .out_value   (out_value),
    .out_invalid (out_invalid)
);

// File: tb/fp_nan_quieter_bench.sv
`timescale 1ns/1ps
module fp_nan_quieter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_op = '0;
    logic        nan2008 = 1'b0;
    logic        out_valid;
    logic [2:0]  out_class;
    logic [31:0] out_value;
    logic        out_invalid;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // behavioural reference state
    logic        m_valid = 1'b0;
    int          m_class = 0;
    logic [31:0] m_value = '0;
    logic        m_inv = 1'b0;
    string       m_tag = "R8";

    always #5 clk = ~clk;

    fp_nan_quieter u_fp_nan_quieter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .nan2008(nan2008), .out_valid(out_valid), .out_class(out_class),
        .out_value(out_value), .out_invalid(out_invalid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        check({m_tag, " valid R7"}, {31'd0, out_valid}, {31'd0, m_valid});
        check({m_tag, " class"}, {29'd0, out_class}, m_class);
        check({m_tag, " value"}, out_value, m_value);
        check({m_tag, " invalid"}, {31'd0, out_invalid}, {31'd0, m_inv});
    endtask

    task automatic model(input logic [31:0] x, input logic mode);
        int e;
        int f;
        logic q;
        logic sig;
        e = int'(x[30:23]);
        f = int'(x[22:0]);
        q = x[22];
        m_value = x;
        m_inv = 1'b0;
        if (e == 0) begin
            m_class = (f == 0) ? 0 : 1;
            m_tag = "R1 R6";
        end else if (e < 255) begin
            m_class = 2;
            m_tag = "R1 R6";
        end else if (f == 0) begin
            m_class = 3;
            m_tag = "R1 R6";
        end else begin
            sig = mode ? !q : q;
            m_class = sig ? 5 : 4;
            if (!sig) m_tag = "R2 R6";
            else if (mode) begin
                m_tag = "R2 R3 R5";
                m_value[22] = 1'b1;
                m_inv = 1'b1;
            end else begin
                m_tag = "R2 R4 R5";
                m_value[22] = 1'b0;
                if (m_value[21:0] == 0) m_value[21] = 1'b1;
                m_inv = 1'b1;
            end
        end
    endtask

    task automatic step(input logic v, input logic [31:0] x, input logic mode);
        @(negedge clk);
        compare_all();
        in_valid = v;
        in_op = x;
        nan2008 = mode;
        m_valid = v;
        if (v) model(x, mode);
        else if (m_tag.len() < 9) m_tag = {m_tag, " R7"};
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        compare_all(); // R8 reset state
        @(negedge clk);
        rst_n = 1'b1;
        compare_all(); // R8 after reset
        // R1 non-NaN classes, both modes
        step(1, 32'h0000_0000, 0);
        step(1, 32'h8000_0000, 1);
        step(1, 32'h0000_0001, 0);
        step(1, 32'h807F_FFFF, 1);
        step(1, 32'h0080_0000, 0);
        step(1, 32'h7F7F_FFFF, 1);
        step(1, 32'h3F80_0000, 0);
        step(1, 32'h7F80_0000, 0);
        step(1, 32'hFF80_0000, 1);
        // R2/R3 2008 convention
        step(1, 32'h7FC0_0000, 1);
        step(1, 32'h7F80_0001, 1);
        step(1, 32'hFFA5_A5A5, 1);
        // R2/R4 legacy convention, including the fix-up
        step(1, 32'h7FC0_0000, 0);
        step(1, 32'hFFC0_0000, 0);
        step(1, 32'h7FE0_0000, 0);
        step(1, 32'h7FC0_0001, 0);
        step(1, 32'h7F80_0001, 0);
        step(1, 32'hFFFF_FFFF, 0);
        // R7 gaps and hold
        step(0, 32'h7FC0_0000, 1);
        step(0, 32'h1234_5678, 0);
        step(1, 32'hFFFF_FFFF, 1);
        step(0, 32'h0000_0000, 0);
        step(1, 32'h7FBF_FFFF, 1);
        step(1, 32'h7FBF_FFFF, 0);
        step(0, 32'h0, 0);
        step(0, 32'h0, 0);
        @(negedge clk);
        compare_all();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule